// File: doc/BRIEF.md
# Memory Type Range Resolver

The block keeps a small set of software-programmed tables and uses them to give every physical address a caching type. The first megabyte is split into 88 fixed slots of three sizes: eight 64 KiB slots up to 0x7FFFF, sixteen 16 KiB slots up to 0xBFFFF and sixty-four 4 KiB slots up to 0xFFFFF. Each slot has its own type field. Above that, and below 1 MiB when the fixed slots are switched off, eight variable ranges apply. Each range is a base/mask pair with a valid bit and can span any power-of-two size from 4 KiB up to the whole address space. An address that no range claims takes a programmed default type.

Software programs the tables through a plain register port. Writes happen on a clock edge and reads are combinational. A read-only capability word tells software how many variable ranges exist and that the fixed slots are present. A lookup port takes a physical address with a request strobe. It returns the resolved type, marked valid, one clock later. When several variable ranges overlap, a fixed precedence order decides the type.

Top module: `memtype_resolver`

## Requirements
- R1: After a synchronous reset, lk_valid is 0 and every register reads 0. That covers all fixed slots, the control word, and every range base and mask. As a result, every lookup returns type 0 until software enables the block.
- R2: The capability word at address 0x61 always reads 0x108. Bits 7:0 hold the variable range count (8) and bit 8 is 1 to show that fixed slots exist. Writes to this address change nothing.
- R3: When the global enable bit (bit 0 of the control word at 0x60) is clear, every lookup returns uncacheable (0), whatever the tables hold.
- R4: With fixed slots enabled, an address below 0x80000 returns the type of slot addr/64 KiB (slots 0..7).
- R5: With fixed slots enabled, an address from 0x80000 to 0xBFFFF returns the type of slot 8 + (addr-0x80000)/16 KiB (slots 8..23).
- R6: With fixed slots enabled, an address from 0xC0000 to 0xFFFFF returns the type of slot 24 + (addr-0xC0000)/4 KiB (slots 24..87).
- R7: The fixed-enable bit is bit 1 of the control word. When it is set, a fixed slot overrides every variable range below 1 MiB. When it is clear, addresses below 1 MiB are resolved by the variable ranges and the default, like any other address.
- R8: Variable range k matches when its valid bit is 1 and (addr & mask) equals (base & mask) on address bits 35:12. A range whose valid bit is 0 never matches.
- R9: An address that neither a fixed slot nor a variable range claims returns the default type, held in bits 6:4 of the control word.
- R10: When variable ranges overlap, the rules apply in this order. If any matching range is uncacheable, the result is uncacheable. If all matching ranges share one type, the result is that type. A mix of write-through and write-back only gives write-through. Any other mix gives uncacheable.
- R11: Types are 3-bit codes: 0 uncacheable, 1 write-combining, 4 write-through, 5 write-protect, 6 write-back. A write to a fixed slot, to a range base or to the control word whose type field holds 2, 3 or 7 is dropped entirely, and the register keeps its old value.
- R12: A lookup request in one cycle gives lk_valid = 1 and lk_type in the next cycle, so back-to-back requests give back-to-back results. Without a request, lk_valid is 0 in the next cycle. A lookup that shares its clock edge with a register write still sees the old tables; the next lookup sees the new ones.
- R13: The register map is as follows:
  - Addresses 0x00-0x57 hold the fixed slots in slot order, with the type in bits 2:0.
  - Address 0x60 holds the control word.
  - Address 0x80+2k holds the base of range k: base bits 35:12 and the type in bits 2:0.
  - Address 0x81+2k holds the mask of range k: mask bits 35:12 and the valid bit in bit 11.
  - Bits with no field read 0, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Combinational read data for reg_addr |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 36 | Physical address to resolve |
| lk_valid | output | 1 | Lookup result valid, one cycle after lk_req |
| lk_type | output | 3 | Resolved memory type |

## Verification
A corrupt stored field shows on reg_rdata in the same cycle that its address is presented. It also shows on lk_type one clock after the first lookup that lands in the slot or range concerned. A fault in the overlap logic or in the slot decode shows only for the particular address and table mix that exercises it. The bench therefore mixes hand-picked boundaries and overlaps with random addresses and random table rewrites, and compares every output on every clock against a behavioural model. Any divergence is reported within one cycle of the lookup or read that exposes it.

// File: rtl/memtype_pkg.sv
package memtype_pkg;

    typedef enum logic [2:0] {
        MT_UC = 3'd0,
        MT_WC = 3'd1,
        MT_WT = 3'd4,
        MT_WP = 3'd5,
        MT_WB = 3'd6
    } mtype_e;

    typedef struct packed {
        logic   global_en;
        logic   fixed_en;
        mtype_e def_type;
    } ctl_t;

    localparam int PAGE_BITS     = 12;
    localparam int FIX_SPAN_BITS = 20;
    localparam int N64           = 8;
    localparam int N16           = 16;
    localparam int N4            = 64;
    localparam int NFIX          = N64 + N16 + N4;
    localparam int FIX_IW        = $clog2(NFIX);

    localparam int REG_AW   = 8;
    localparam int REG_DW   = 64;
    localparam int REG_VAR0 = 'h80;
    localparam logic [REG_AW-1:0] REG_CTL = 8'h60;
    localparam logic [REG_AW-1:0] REG_CAP = 8'h61;

    function automatic logic type_legal(input logic [2:0] t);
        case (t)
            3'd0, 3'd1, 3'd4, 3'd5, 3'd6: return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/memtype_regs.sv
module memtype_regs
    import memtype_pkg::*;
#(
    parameter int PA_W    = 36,
    parameter int NUM_VAR = 8
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   reg_wr,
    input  logic [REG_AW-1:0]                      reg_addr,
    input  logic [REG_DW-1:0]                      reg_wdata,
    output logic [REG_DW-1:0]                      reg_rdata,
    output mtype_e [NFIX-1:0]                      fix_type,
    output ctl_t                                   ctl,
    output logic [NUM_VAR-1:0][PA_W-PAGE_BITS-1:0] var_base,
    output logic [NUM_VAR-1:0][PA_W-PAGE_BITS-1:0] var_mask,
    output logic [NUM_VAR-1:0]                     var_valid,
    output mtype_e [NUM_VAR-1:0]                   var_type
);

    mtype_e wtype;
    logic   wtype_ok;
    logic   unused_wdata;

    assign wtype        = mtype_e'(reg_wdata[2:0]);
    assign wtype_ok     = type_legal(reg_wdata[2:0]);
    assign unused_wdata = ^{reg_wdata[REG_DW-1:PA_W], reg_wdata[10:7], reg_wdata[3]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NFIX; i++) fix_type[i] <= MT_UC;
            ctl <= '{global_en: 1'b0, fixed_en: 1'b0, def_type: MT_UC};
            for (int k = 0; k < NUM_VAR; k++) begin
                var_base[k]  <= '0;
                var_mask[k]  <= '0;
                var_valid[k] <= 1'b0;
                var_type[k]  <= MT_UC;
            end
        end else if (reg_wr) begin
            for (int i = 0; i < NFIX; i++) begin
                if (reg_addr == REG_AW'(i) && wtype_ok) fix_type[i] <= wtype;
            end
            if (reg_addr == REG_CTL && type_legal(reg_wdata[6:4])) begin
                ctl.global_en <= reg_wdata[0];
                ctl.fixed_en  <= reg_wdata[1];
                ctl.def_type  <= mtype_e'(reg_wdata[6:4]);
            end
            for (int k = 0; k < NUM_VAR; k++) begin
                if (reg_addr == REG_AW'(REG_VAR0 + 2 * k) && wtype_ok) begin
                    var_base[k] <= reg_wdata[PA_W-1:PAGE_BITS];
                    var_type[k] <= wtype;
                end
                if (reg_addr == REG_AW'(REG_VAR0 + 2 * k + 1)) begin
                    var_mask[k]  <= reg_wdata[PA_W-1:PAGE_BITS];
                    var_valid[k] <= reg_wdata[11];
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NFIX; i++) begin
            if (reg_addr == REG_AW'(i)) reg_rdata[2:0] = fix_type[i];
        end
        if (reg_addr == REG_CTL) begin
            reg_rdata[0]   = ctl.global_en;
            reg_rdata[1]   = ctl.fixed_en;
            reg_rdata[6:4] = ctl.def_type;
        end
        if (reg_addr == REG_CAP) begin
            reg_rdata[7:0] = 8'(NUM_VAR);
            reg_rdata[8]   = 1'b1;
        end
        for (int k = 0; k < NUM_VAR; k++) begin
            if (reg_addr == REG_AW'(REG_VAR0 + 2 * k)) begin
                reg_rdata[PA_W-1:PAGE_BITS] = var_base[k];
                reg_rdata[2:0]              = var_type[k];
            end
            if (reg_addr == REG_AW'(REG_VAR0 + 2 * k + 1)) begin
                reg_rdata[PA_W-1:PAGE_BITS] = var_mask[k];
                reg_rdata[11]               = var_valid[k];
            end
        end
    end

endmodule

// File: rtl/memtype_fixed_lut.sv
module memtype_fixed_lut
    import memtype_pkg::*;
(
    input  logic [FIX_SPAN_BITS-PAGE_BITS-1:0] page_lo,
    input  mtype_e [NFIX-1:0]                  fix_type,
    output mtype_e                             slot_type
);

    logic [FIX_IW-1:0] slot;

    always_comb begin
        if (!page_lo[7]) begin
            slot = FIX_IW'(page_lo[6:4]);
        end else if (!page_lo[6]) begin
            slot = FIX_IW'(N64) + FIX_IW'(page_lo[5:2]);
        end else begin
            slot = FIX_IW'(N64 + N16) + FIX_IW'(page_lo[5:0]);
        end
    end

    assign slot_type = fix_type[slot];

endmodule

// File: rtl/memtype_var_match.sv
module memtype_var_match
    import memtype_pkg::*;
#(
    parameter int PA_W    = 36,
    parameter int NUM_VAR = 8
) (
    input  logic [PA_W-PAGE_BITS-1:0]              page,
    input  logic [NUM_VAR-1:0][PA_W-PAGE_BITS-1:0] var_base,
    input  logic [NUM_VAR-1:0][PA_W-PAGE_BITS-1:0] var_mask,
    input  logic [NUM_VAR-1:0]                     var_valid,
    input  mtype_e [NUM_VAR-1:0]                   var_type,
    output logic [7:0]                             seen
);

    logic [NUM_VAR-1:0] hit;

    for (genvar k = 0; k < NUM_VAR; k++) begin : g_range
        assign hit[k] = var_valid[k] && (((page ^ var_base[k]) & var_mask[k]) == '0);
    end

    always_comb begin
        seen = '0;
        for (int k = 0; k < NUM_VAR; k++) begin
            if (hit[k]) seen[var_type[k]] = 1'b1;
        end
    end

endmodule

// File: rtl/memtype_resolver.sv
module memtype_resolver
    import memtype_pkg::*;
#(
    parameter int PA_W    = 36,
    parameter int NUM_VAR = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              lk_req,
    input  logic [PA_W-1:0]   lk_addr,
    output logic              lk_valid,
    output logic [2:0]        lk_type
);

    localparam logic [7:0] WT_WB_MIX = (8'd1 << MT_WT) | (8'd1 << MT_WB);

    mtype_e [NFIX-1:0]                      fix_type;
    ctl_t                                   ctl;
    logic [NUM_VAR-1:0][PA_W-PAGE_BITS-1:0] var_base;
    logic [NUM_VAR-1:0][PA_W-PAGE_BITS-1:0] var_mask;
    logic [NUM_VAR-1:0]                     var_valid;
    mtype_e [NUM_VAR-1:0]                   var_type;
    mtype_e                                 fix_res;
    mtype_e                                 var_res;
    mtype_e                                 next_type;
    mtype_e                                 res_q;
    logic [7:0]                             seen;
    logic                                   below_fix;
    logic                                   unused_addr;

    assign unused_addr = ^lk_addr[PAGE_BITS-1:0];

    memtype_regs #(.PA_W(PA_W), .NUM_VAR(NUM_VAR)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .fix_type (fix_type),
        .ctl      (ctl),
        .var_base (var_base),
        .var_mask (var_mask),
        .var_valid(var_valid),
        .var_type (var_type)
    );

    memtype_fixed_lut u_fixed (
        .page_lo  (lk_addr[FIX_SPAN_BITS-1:PAGE_BITS]),
        .fix_type (fix_type),
        .slot_type(fix_res)
    );

    memtype_var_match #(.PA_W(PA_W), .NUM_VAR(NUM_VAR)) u_var (
        .page     (lk_addr[PA_W-1:PAGE_BITS]),
        .var_base (var_base),
        .var_mask (var_mask),
        .var_valid(var_valid),
        .var_type (var_type),
        .seen     (seen)
    );

    always_comb begin
        var_res = MT_UC;
        if (seen == '0) begin
            var_res = ctl.def_type;
        end else if (seen[MT_UC]) begin
            var_res = MT_UC;
        end else if ($onehot(seen)) begin
            for (int t = 0; t < 8; t++) begin
                if (seen[t]) var_res = mtype_e'(3'(t));
            end
        end else if (seen == WT_WB_MIX) begin
            var_res = MT_WT;
        end
    end

    assign below_fix = (lk_addr[PA_W-1:FIX_SPAN_BITS] == '0);

    always_comb begin
        if (!ctl.global_en)                 next_type = MT_UC;
        else if (below_fix && ctl.fixed_en) next_type = fix_res;
        else                                next_type = var_res;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_valid <= 1'b0;
            res_q    <= MT_UC;
        end else begin
            lk_valid <= lk_req;
            if (lk_req) res_q <= next_type;
        end
    end

    assign lk_type = res_q;

endmodule

// File: rtl/memtype_resolver_chk.sv
module memtype_resolver_chk
    import memtype_pkg::*;
#(
    parameter int PA_W    = 36,
    parameter int NUM_VAR = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        reg_wr,
    input logic [REG_AW-1:0]           reg_addr,
    input logic [2:0]                  wdata_type,
    input logic [REG_DW-1:0]           reg_rdata,
    input logic                        lk_req,
    input logic [PA_W-1:0]             lk_addr,
    input logic                        lk_valid,
    input logic [2:0]                  lk_type,
    input logic                        global_en,
    input logic                        fixed_en,
    input logic [NFIX-1:0][2:0]        fix_flat
);

    logic [19:0]       lo;
    logic [FIX_IW-1:0] slot_c;
    logic              low_meg;

    assign lo      = lk_addr[19:0];
    assign low_meg = (lk_addr[PA_W-1:20] == '0);

    always_comb begin
        if (lo < 20'h80000)      slot_c = FIX_IW'(lo / 20'h10000);
        else if (lo < 20'hC0000) slot_c = FIX_IW'(8 + (lo - 20'h80000) / 20'h4000);
        else                     slot_c = FIX_IW'(24 + (lo - 20'hC0000) / 20'h1000);
    end

    assert_cap_value_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == REG_CAP) |-> (reg_rdata == {55'd0, 1'b1, 8'(NUM_VAR)}));

    assert_global_off_uc_R3: assert property (@(posedge clk) disable iff (rst)
        $past(lk_req && !global_en) |-> (lk_type == 3'd0));

    assert_fixed_wins_R7: assert property (@(posedge clk) disable iff (rst)
        $past(lk_req && global_en && fixed_en && low_meg) |-> (lk_type == $past(fix_flat[slot_c])));

    assert_legal_result_R11: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> (lk_type inside {3'd0, 3'd1, 3'd4, 3'd5, 3'd6}));

    assert_reserved_dropped_R11: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_addr < REG_AW'(NFIX)) && !(wdata_type inside {3'd0, 3'd1, 3'd4, 3'd5, 3'd6}))
        |=> $stable(fix_flat));

endmodule

bind memtype_resolver memtype_resolver_chk #(.PA_W(PA_W), .NUM_VAR(NUM_VAR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .wdata_type(reg_wdata[2:0]),
    .reg_rdata (reg_rdata),
    .lk_req    (lk_req),
    .lk_addr   (lk_addr),
    .lk_valid  (lk_valid),
    .lk_type   (lk_type),
    .global_en (ctl.global_en),
    .fixed_en  (ctl.fixed_en),
    .fix_flat  (fix_type)
);

// File: tb/test_memtype_resolver.sv
`timescale 1ns/1ps
module test_memtype_resolver;

    localparam int PA_W = 36;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        lk_req = 1'b0;
    logic [PA_W-1:0] lk_addr = '0;
    logic        lk_valid;
    logic [2:0]  lk_type;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";

    int     m_fix [88];
    int     m_def;
    bit     m_gen, m_fen;
    longint m_base [8];
    longint m_mask [8];
    bit     m_val [8];
    int     m_vty [8];
    bit     exp_valid = 1'b0;
    int     exp_type = 0;

    memtype_resolver i_memtype_resolver (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req),
        .lk_addr(lk_addr), .lk_valid(lk_valid), .lk_type(lk_type)
    );

    always #2.5 clk = ~clk;

    function automatic bit legal(int t);
        return (t == 0 || t == 1 || t == 4 || t == 5 || t == 6);
    endfunction

    function automatic int lp(int i);
        case (i % 5)
            0: return 0;
            1: return 1;
            2: return 4;
            3: return 5;
            default: return 6;
        endcase
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 88; i++) m_fix[i] = 0;
        m_def = 0; m_gen = 0; m_fen = 0;
        for (int k = 0; k < 8; k++) begin
            m_base[k] = 0; m_mask[k] = 0; m_val[k] = 0; m_vty[k] = 0;
        end
    endtask

    function automatic int m_resolve(longint a);
        int cnt [8];
        int nhit = 0;
        int distinct = 0;
        int only = 0;
        if (!m_gen) return 0;
        if (a < 'h100000 && m_fen) begin
            if (a < 'h80000) return m_fix[a / 65536];
            if (a < 'hC0000) return m_fix[8 + (a - 'h80000) / 16384];
            return m_fix[24 + (a - 'hC0000) / 4096];
        end
        for (int t = 0; t < 8; t++) cnt[t] = 0;
        for (int k = 0; k < 8; k++) begin
            if (m_val[k] && (((a >> 12) & m_mask[k]) == (m_base[k] & m_mask[k]))) begin
                cnt[m_vty[k]]++;
                nhit++;
            end
        end
        if (nhit == 0) return m_def;
        if (cnt[0] > 0) return 0;
        for (int t = 0; t < 8; t++) if (cnt[t] > 0) begin distinct++; only = t; end
        if (distinct == 1) return only;
        if (distinct == 2 && cnt[4] > 0 && cnt[6] > 0) return 4;
        return 0;
    endfunction

    task automatic m_write(int ra, logic [63:0] d);
        if (ra < 88) begin
            if (legal(int'(d[2:0]))) m_fix[ra] = int'(d[2:0]);
        end else if (ra == 'h60) begin
            if (legal(int'(d[6:4]))) begin
                m_gen = d[0]; m_fen = d[1]; m_def = int'(d[6:4]);
            end
        end else if (ra >= 'h80 && ra < 'h90) begin
            if (ra % 2 == 0) begin
                if (legal(int'(d[2:0]))) begin
                    m_base[(ra - 'h80) / 2] = longint'(d[35:12]);
                    m_vty[(ra - 'h80) / 2]  = int'(d[2:0]);
                end
            end else begin
                m_mask[(ra - 'h80) / 2] = longint'(d[35:12]);
                m_val[(ra - 'h80) / 2]  = d[11];
            end
        end
    endtask

    function automatic logic [63:0] m_read(int ra);
        logic [63:0] r = '0;
        if (ra < 88) r[2:0] = 3'(m_fix[ra]);
        else if (ra == 'h60) begin r[0] = m_gen; r[1] = m_fen; r[6:4] = 3'(m_def); end
        else if (ra == 'h61) r = 64'h108;
        else if (ra >= 'h80 && ra < 'h90) begin
            if (ra % 2 == 0) begin
                r[35:12] = 24'(m_base[(ra - 'h80) / 2]);
                r[2:0]   = 3'(m_vty[(ra - 'h80) / 2]);
            end else begin
                r[35:12] = 24'(m_mask[(ra - 'h80) / 2]);
                r[11]    = m_val[(ra - 'h80) / 2];
            end
        end
        return r;
    endfunction

    task automatic fail(string req, string what, logic [63:0] a, logic [63:0] e);
        n_bad++;
        $display("FAIL %s %s: actual %h expected %h", req, what, a, e);
    endtask

    task automatic chk(string req, string what, logic [63:0] a, logic [63:0] e);
        n_cmp++;
        if (a !== e) fail(req, what, a, e);
    endtask

    // reference model update at the active edge (inputs are stable here)
    always @(posedge clk) begin
        if (rst) begin
            m_reset();
            exp_valid = 1'b0;
        end else begin
            exp_valid = lk_req;
            if (lk_req) exp_type = m_resolve(longint'(lk_addr));
            if (reg_wr) m_write(int'(reg_addr), reg_wdata);
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(tag, "lk_valid", 64'(lk_valid), 64'(exp_valid));
            if (exp_valid) chk(tag, "lk_type", 64'(lk_type), 64'(exp_type));
            chk(tag, "reg_rdata", reg_rdata, m_read(int'(reg_addr)));
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(int a, logic [63:0] d);
        reg_wr = 1'b1; reg_addr = 8'(a); reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(int a);
        reg_addr = 8'(a);
        tick();
    endtask

    task automatic look(longint a);
        lk_req = 1'b1; lk_addr = PA_W'(a);
        tick();
        lk_req = 1'b0;
    endtask

    task automatic look_chk(string req, longint a, int e);
        look(a);
        chk(req, "lookup type", 64'(lk_type), 64'(e));
    endtask

    function automatic logic [63:0] basew(longint page, int t);
        return (64'(page) << 12) | 64'(t);
    endfunction

    function automatic logic [63:0] maskw(longint m, bit v);
        return (64'(m) << 12) | (64'(v) << 11);
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R12 watchdog: actual %0d expected %0d", 0, 1);
        summary();
        $finish;
    end

    initial begin
        tag = "R1";
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1", "lk_valid after reset", 64'(lk_valid), 64'd0);
        rd('h60); chk("R1", "control after reset", reg_rdata, 64'd0);
        rd(5);    chk("R1", "fixed slot after reset", reg_rdata, 64'd0);
        rd('h81); chk("R1", "range mask after reset", reg_rdata, 64'd0);
        look_chk("R1", 'h1234_5000, 0);

        tag = "R3";
        wr('h60, (64'd6 << 4) | 64'd2);
        look_chk("R3", 'h3_0000_0000, 0);

        tag = "R2";
        wr('h61, 64'hFFFF_FFFF);
        rd('h61); chk("R2", "capability", reg_rdata, 64'h108);

        tag = "R13";
        for (int i = 0; i < 88; i++) wr(i, 64'(lp(i)));
        wr('h80, basew('h40000, 6));   wr('h81, maskw('hFC0000, 1));
        wr('h82, basew('h40000, 4));   wr('h83, maskw('hFF0000, 1));
        wr('h84, basew('h50000, 0));   wr('h85, maskw('hFFFFFF, 1));
        wr('h86, basew('h80000, 1));   wr('h87, maskw('hF80000, 1));
        wr('h88, basew('h80000, 5));   wr('h89, maskw('hFFFF00, 1));
        wr('h8A, basew('h0, 6));       wr('h8B, maskw('hFFFE00, 1));
        wr('h8C, basew('hFFFFFF, 5));  wr('h8D, maskw('hFFFFFF, 1));
        wr('h8E, basew('h200000, 0));  wr('h8F, maskw('hF00000, 0));
        wr('h60, (64'd1 << 4) | 64'd3);
        rd(3);     chk("R13", "slot 3", reg_rdata, 64'd5);
        rd('h80);  chk("R13", "base 0", reg_rdata, basew('h40000, 6));
        rd('h83);  chk("R13", "mask 1", reg_rdata, maskw('hFF0000, 1));
        rd('h60);  chk("R13", "control", reg_rdata, 64'h13);
        rd('h70);  chk("R13", "unmapped", reg_rdata, 64'd0);

        tag = "R4";
        look_chk("R4", 'h00000, 0);
        look_chk("R4", 'h35000, 5);
        look_chk("R4", 'h7FFFF, 4);
        tag = "R5";
        look_chk("R5", 'h80000, 5);
        look_chk("R5", 'h84000, 6);
        look_chk("R5", 'hBFFFF, 5);
        tag = "R6";
        look_chk("R6", 'hC0000, 6);
        look_chk("R6", 'hC1000, 0);
        look_chk("R6", 'hFFFFF, 4);

        tag = "R8";
        look_chk("R8", 'h6000_0000, 6);
        look_chk("R8", 'h8010_0000, 1);
        look_chk("R8", 'hF_FFFF_F800, 5);
        look_chk("R8", 'h10_0000, 6);
        look_chk("R8", 'h15_0000, 6);
        tag = "R9";
        look_chk("R9", 'hF_FFFF_E000, 1);
        look_chk("R9", 'h2_1000_0000, 1);
        tag = "R10";
        look_chk("R10", 'h4000_0000, 4);
        look_chk("R10", 'h5000_0000, 0);
        look_chk("R10", 'h5000_1000, 6);
        look_chk("R10", 'h8000_0000, 0);

        tag = "R7";
        wr('h60, (64'd1 << 4) | 64'd1);
        look_chk("R7", 'h7FFFF, 6);
        look_chk("R7", 'hC1000, 6);
        wr('h60, (64'd1 << 4) | 64'd3);
        look_chk("R7", 'hC1000, 0);

        tag = "R11";
        wr(3, 64'd2);
        rd(3); chk("R11", "slot 3 after code 2", reg_rdata, 64'd5);
        wr(3, 64'd7);
        look_chk("R11", 'h30000, 5);
        wr('h60, (64'd3 << 4) | 64'd3);
        rd('h60); chk("R11", "control after code 3", reg_rdata, 64'h13);
        wr('h80, basew('h40000, 7));
        rd('h80); chk("R11", "base 0 after code 7", reg_rdata, basew('h40000, 6));

        tag = "R12";
        reg_wr = 1'b1; reg_addr = 8'h60; reg_wdata = (64'd4 << 4) | 64'd3;
        lk_req = 1'b1; lk_addr = PA_W'('h3_0000_0000);
        tick();
        reg_wr = 1'b0;
        chk("R12", "same-edge lookup sees old default", 64'(lk_type), 64'd1);
        chk("R12", "valid after request", 64'(lk_valid), 64'd1);
        tick();
        chk("R12", "next lookup sees new default", 64'(lk_type), 64'd4);
        lk_addr = PA_W'('h5000_0000);
        tick();
        chk("R12", "back-to-back result", 64'(lk_type), 64'd0);
        lk_req = 1'b0;
        tick();
        chk("R12", "valid drops without request", 64'(lk_valid), 64'd0);

        tag = "R10";
        for (int n = 0; n < 600; n++) begin
            if (n % 9 == 0) wr($urandom_range(0, 87), 64'($urandom_range(0, 7)));
            if (n % 23 == 0) wr('h80 + 2 * $urandom_range(0, 7),
                                basew(longint'($urandom_range('h3F000, 'h90000)), $urandom_range(0, 7)));
            if (n % 57 == 0) wr('h60, 64'($urandom_range(0, 127)));
            if (n % 3 == 0)      look(longint'($urandom_range(0, 'hFFFFF)));
            else if (n % 3 == 1) look(longint'($urandom_range('h3F00_0000, 'h9FFF_FFFF)));
            else                 look(longint'({$urandom, $urandom}) & 64'hF_FFFF_FFFF);
        end

        tick();
        summary();
        $finish;
    end

endmodule